// File: doc/BRIEF.md
# Translation Walk Fault Classifier

This block sits beside a two-level page table walker and decides, for each memory request, whether the access faults and where. A request carries the access size, the virtual address, the translation enable, the two per-table walk disables, the table split width, the extended-mode bit, the secure and non-secure copies of the forced access-flag bit and the security state of the request. The block checks alignment first. With translation on, it then asks for the first-level descriptor and, when that descriptor points to a second-level table, for the second-level descriptor.

Descriptors arrive over a valid/ready pair. While it waits, the block raises `descReady` and shows on `descLevel` which level it wants. The result appears as a single-cycle `done` pulse carrying a 3-bit fault code. Code 0 means no fault, 1 means misaligned, 2 means section-level translation fault, 3 means page-level translation fault, 4 means section-level access-flag fault and 5 means page-level access-flag fault. Only the fault with the highest priority is reported: alignment first, then walk disable, then invalid descriptor, then access flag.

Top module: `walk_fault_chk`

## Requirements
- R1: A request whose address is not a multiple of its size gives code 1. Size encodes 0 as byte (never misaligned), 1 as halfword (address bit 0 must be clear), 2 as word (bits 1:0 must be clear) and 3 as doubleword (bits 2:0 must be clear).
- R2: The alignment check applies whether translation is on or off, and it outranks all other faults. A misaligned request fetches no descriptor and finishes one cycle after acceptance.
- R3: With translation off, an aligned request gives code 0 with no descriptor fetch, and `done` is high in the cycle right after the accept edge.
- R4: With translation on, the request uses the upper table when `tableSplit` N is nonzero and the top N address bits are not all zero; otherwise it uses the lower table. If the walk for the selected table is disabled (`walkOff1` or `walkOff0`), the result is code 2 with no fetch, one cycle after acceptance.
- R5: A first-level descriptor with bits[1:0] equal to 00 or 11 gives code 2. Bits 10 mark a section and end the walk at level one.
- R6: A first-level descriptor with bits[1:0] equal to 01 starts a second fetch with `descLevel`=1 (a first-level fetch shows `descLevel`=0). A second-level descriptor with bits[1:0] equal to 00 gives code 3.
- R7: The access-flag check is active only when `extMode`=1 and the selected forced-flag copy is 1. A section descriptor with bit 10 clear then gives code 4. With the check inactive the same descriptor gives code 0.
- R8: With the access-flag check active, a valid second-level descriptor with bit 4 clear gives code 5. A level-two invalid encoding outranks the access flag.
- R9: The forced-flag copy is `forceAccSec` when `reqSecure`=1 and `forceAccNs` otherwise. The other copy has no effect.
- R10: `done` lasts exactly one cycle and is followed by a return to ready. `reqReady` and `descReady` are never high together. After reset `reqReady`=1, `done`=0 and `descReady`=0. The fault code never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and accepting a request |
| reqSize | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| reqVa | input | VA_W | Virtual address |
| mmuOn | input | 1 | Translation enable |
| walkOff0 | input | 1 | Walk disable for the lower table |
| walkOff1 | input | 1 | Walk disable for the upper table |
| tableSplit | input | SPLIT_W | Number of top address bits that select the upper table |
| extMode | input | 1 | Extended descriptor mode |
| forceAccSec | input | 1 | Forced access-flag bit, secure copy |
| forceAccNs | input | 1 | Forced access-flag bit, non-secure copy |
| reqSecure | input | 1 | Security state of the request |
| descReady | output | 1 | Waiting for a descriptor |
| descLevel | output | 1 | Level wanted (0 first, 1 second) |
| descValid | input | 1 | Descriptor present |
| descWord | input | DESC_W | Descriptor data |
| done | output | 1 | One-cycle result strobe |
| faultCode | output | 3 | Fault class, valid while done is high |

## Verification
If the walk state is wrong, the error shows at the ports within a cycle or two. There may be an extra or missing `descReady` cycle, a `descLevel` of the wrong value, or a `done` pulse that comes early, late or twice. A wrong fault code register shows only on the `done` pulse of the request it affects. So every request's code, fetch count and fetch levels are compared, and the early-exit cases also have their latency compared. The forced-flag copy not selected by the security state is randomised independently, so a wrong choice of copy flips codes 4 and 5 to 0, or the other way round.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_ALIGN    = 3'd1,
    FC_SECT_XLT = 3'd2,
    FC_PAGE_XLT = 3'd3,
    FC_SECT_ACC = 3'd4,
    FC_PAGE_ACC = 3'd5
  } faultCode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_DONE = 2'd3
  } walkState_e;

  typedef struct packed {
    logic capReq;
    logic evalL1;
    logic evalL2;
  } dpStrobe_t;
endpackage

// File: rtl/wfc_datapath.sv
module wfc_datapath
  import wfc_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int DESC_W      = 32,
  parameter int SPLIT_W     = 3,
  parameter int L1_FLAG_BIT = 10,
  parameter int L2_FLAG_BIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [1:0]         reqSize,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               mmuOn,
  input  logic               walkOff0,
  input  logic               walkOff1,
  input  logic [SPLIT_W-1:0] tableSplit,
  input  logic               extMode,
  input  logic               forceAccSec,
  input  logic               forceAccNs,
  input  logic               reqSecure,
  input  logic [DESC_W-1:0]  descWord,
  output logic               earlyStop,
  output logic               l1Coarse,
  output logic [2:0]         faultCode
);
  localparam int SHIFT_W = $clog2(VA_W + 1) + 1;

  logic [2:0]      sizeMask;
  logic            alignBad;
  logic [VA_W-1:0] hiBits;
  logic            useHi;
  logic            walkDis;
  logic            accOn;
  logic [2:0]      codeQ;

  always_comb begin
    unique case (reqSize)
      2'd0:    sizeMask = 3'b000;
      2'd1:    sizeMask = 3'b001;
      2'd2:    sizeMask = 3'b011;
      default: sizeMask = 3'b111;
    endcase
    alignBad = |(reqVa[2:0] & sizeMask);
    hiBits   = reqVa >> (SHIFT_W'(VA_W) - SHIFT_W'(tableSplit));
    useHi    = (tableSplit != '0) && (hiBits != '0);
    walkDis  = useHi ? walkOff1 : walkOff0;
    earlyStop = alignBad | ~mmuOn | walkDis;
    l1Coarse  = (descWord[1:0] == 2'b01);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= FC_NONE;
      accOn <= 1'b0;
    end else if (strobe.capReq) begin
      accOn <= extMode & (reqSecure ? forceAccSec : forceAccNs);
      if (alignBad)     codeQ <= FC_ALIGN;
      else if (!mmuOn)  codeQ <= FC_NONE;
      else if (walkDis) codeQ <= FC_SECT_XLT;
      else              codeQ <= FC_NONE;
    end else if (strobe.evalL1) begin
      unique case (descWord[1:0])
        2'b00, 2'b11: codeQ <= FC_SECT_XLT;
        2'b10:        codeQ <= (accOn && !descWord[L1_FLAG_BIT]) ? FC_SECT_ACC : FC_NONE;
        default:      codeQ <= FC_NONE;
      endcase
    end else if (strobe.evalL2) begin
      if (descWord[1:0] == 2'b00)             codeQ <= FC_PAGE_XLT;
      else if (accOn && !descWord[L2_FLAG_BIT]) codeQ <= FC_PAGE_ACC;
      else                                     codeQ <= FC_NONE;
    end
  end

  assign faultCode = codeQ;

  // R1
  align_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capReq && alignBad |=> faultCode == FC_ALIGN);

  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultCode <= FC_PAGE_ACC);

  // R6
  l2_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalL2 && descWord[1:0] == 2'b00 |=> faultCode == FC_PAGE_XLT);
endmodule

// File: rtl/wfc_ctrl.sv
module wfc_ctrl
  import wfc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      descValid,
  input  logic      earlyStop,
  input  logic      l1Coarse,
  output logic      reqReady,
  output logic      descReady,
  output logic      descLevel,
  output logic      done,
  output dpStrobe_t strobe
);
  walkState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid)  stateNext = earlyStop ? ST_DONE : ST_L1;
      ST_L1:   if (descValid) stateNext = l1Coarse ? ST_L2 : ST_DONE;
      ST_L2:   if (descValid) stateNext = ST_DONE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady      = (state == ST_IDLE);
  assign descReady     = (state == ST_L1) || (state == ST_L2);
  assign descLevel     = (state == ST_L2);
  assign done          = (state == ST_DONE);
  assign strobe.capReq = reqReady & reqValid;
  assign strobe.evalL1 = (state == ST_L1) & descValid;
  assign strobe.evalL2 = (state == ST_L2) & descValid;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);

  // R10
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && descReady));

  // R3
  early_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capReq && earlyStop |=> done);

  // R6
  l2_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalL1 && l1Coarse |=> descReady && descLevel);
endmodule

// File: rtl/walk_fault_chk.sv
module walk_fault_chk
  import wfc_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int DESC_W  = 32,
  parameter int SPLIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqSize,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               mmuOn,
  input  logic               walkOff0,
  input  logic               walkOff1,
  input  logic [SPLIT_W-1:0] tableSplit,
  input  logic               extMode,
  input  logic               forceAccSec,
  input  logic               forceAccNs,
  input  logic               reqSecure,
  output logic               descReady,
  output logic               descLevel,
  input  logic               descValid,
  input  logic [DESC_W-1:0]  descWord,
  output logic               done,
  output logic [2:0]         faultCode
);
  dpStrobe_t strobe;
  logic      earlyStop;
  logic      l1Coarse;

  wfc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .descValid(descValid),
    .earlyStop(earlyStop), .l1Coarse(l1Coarse), .reqReady(reqReady),
    .descReady(descReady), .descLevel(descLevel), .done(done), .strobe(strobe)
  );

  wfc_datapath #(.VA_W(VA_W), .DESC_W(DESC_W), .SPLIT_W(SPLIT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqSize(reqSize), .reqVa(reqVa),
    .mmuOn(mmuOn), .walkOff0(walkOff0), .walkOff1(walkOff1),
    .tableSplit(tableSplit), .extMode(extMode), .forceAccSec(forceAccSec),
    .forceAccNs(forceAccNs), .reqSecure(reqSecure), .descWord(descWord),
    .earlyStop(earlyStop), .l1Coarse(l1Coarse), .faultCode(faultCode)
  );
endmodule

// File: tb/walk_fault_chk_tb.sv
`timescale 1ns/1ps
module walk_fault_chk_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqVa = '0;
  logic        mmuOn = 1'b0, walkOff0 = 1'b0, walkOff1 = 1'b0;
  logic [2:0]  tableSplit = '0;
  logic        extMode = 1'b0, forceAccSec = 1'b0, forceAccNs = 1'b0, reqSecure = 1'b0;
  logic        descReady, descLevel;
  logic        descValid = 1'b0;
  logic [31:0] descWord = '0;
  logic        done;
  logic [2:0]  faultCode;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  logic [31:0] tL1, tL2;

  always #2 clk = ~clk;

  walk_fault_chk dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSize(reqSize), .reqVa(reqVa), .mmuOn(mmuOn), .walkOff0(walkOff0),
    .walkOff1(walkOff1), .tableSplit(tableSplit), .extMode(extMode),
    .forceAccSec(forceAccSec), .forceAccNs(forceAccNs), .reqSecure(reqSecure),
    .descReady(descReady), .descLevel(descLevel), .descValid(descValid),
    .descWord(descWord), .done(done), .faultCode(faultCode)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  function automatic void refModel(output int code, output int fetches, output bit early);
    logic [2:0] m;
    bit useHi, acc;
    m = (reqSize == 0) ? 3'b000 : (reqSize == 1) ? 3'b001 : (reqSize == 2) ? 3'b011 : 3'b111;
    fetches = 0; early = 1'b1; code = 0;
    if ((reqVa[2:0] & m) != 0) begin code = 1; return; end
    if (!mmuOn) begin code = 0; return; end
    useHi = (tableSplit != 0) && ((reqVa >> (32 - int'(tableSplit))) != 0);
    if (useHi ? walkOff1 : walkOff0) begin code = 2; return; end
    early = 1'b0;
    acc = extMode && (reqSecure ? forceAccSec : forceAccNs);
    fetches = 1;
    case (tL1[1:0])
      2'b00, 2'b11: code = 2;
      2'b10:        code = (acc && !tL1[10]) ? 4 : 0;
      default: begin
        fetches = 2;
        if (tL2[1:0] == 2'b00)       code = 3;
        else if (acc && !tL2[4])     code = 5;
        else                         code = 0;
      end
    endcase
  endfunction

  function automatic string tagFor(input int code, input bit early);
    case (code)
      1: return "R1";
      2: return early ? "R4" : "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return early ? "R3" : "R10";
    endcase
  endfunction

  task automatic runReq(input string tagIn);
    int expCode, expFetch, gotFetch, gotCode, lat;
    bit early, seen;
    string tag;
    refModel(expCode, expFetch, early);
    tag = (tagIn == "") ? tagFor(expCode, early) : tagIn;
    gotFetch = 0; seen = 1'b0; gotCode = -1; lat = 0;
    @(negedge clk);
    check(tag, "reqReady before request", int'(reqReady), 1);
    reqValid = 1'b1;
    @(posedge clk);
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      reqValid = 1'b0;
      descValid = 1'b0;
      if (done) begin
        seen = 1'b1; gotCode = int'(faultCode); lat = cyc;
        break;
      end
      if (descReady) begin
        check(tag, "descLevel on fetch", int'(descLevel), gotFetch);
        descWord = descLevel ? tL2 : tL1;
        descValid = 1'b1;
        gotFetch++;
      end
    end
    descValid = 1'b0;
    check(tag, "done seen", int'(seen), 1);
    check(tag, "fault code", gotCode, expCode);
    check(tag, "descriptor fetches", gotFetch, expFetch);
    if (early) check(tag, "early latency", lat, 1);
  endtask

  task automatic setReq(input logic [1:0] sz, input logic [31:0] va, input bit mmu,
                        input bit xp, input bit fs, input bit fn, input bit sec);
    reqSize = sz; reqVa = va; mmuOn = mmu; extMode = xp;
    forceAccSec = fs; forceAccNs = fn; reqSecure = sec;
    walkOff0 = 1'b0; walkOff1 = 1'b0; tableSplit = 3'd0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 150000 && !finished) begin
        failCount++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycleCount);
        $display("[TB] %0d tests run, %0d failed", testCount, failCount);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R10", "reset reqReady", int'(reqReady), 1);
    check("R10", "reset done", int'(done), 0);
    check("R10", "reset descReady", int'(descReady), 0);

    // R1: each size with a misaligned address, translation on
    tL1 = 32'h0000_0402; tL2 = 32'h0000_0012;
    setReq(2'd1, 32'h1001, 1, 0, 0, 0, 0); runReq("R1");
    setReq(2'd2, 32'h1002, 1, 0, 0, 0, 0); runReq("R1");
    setReq(2'd3, 32'h1004, 1, 0, 0, 0, 0); runReq("R1");
    setReq(2'd0, 32'h1007, 1, 0, 0, 0, 0); runReq("R1");
    // R2: misaligned with translation off, and with walk disabled
    setReq(2'd2, 32'h2003, 0, 0, 0, 0, 0); runReq("R2");
    setReq(2'd1, 32'h2001, 1, 0, 0, 0, 0); walkOff0 = 1'b1; runReq("R2");
    // R3: translation off, aligned
    setReq(2'd3, 32'h2008, 0, 1, 1, 1, 0); runReq("R3");
    // R4: split selects the upper table
    setReq(2'd2, 32'h8000_0000, 1, 0, 0, 0, 0); tableSplit = 3'd1; walkOff1 = 1'b1; runReq("R4");
    setReq(2'd2, 32'h0800_0000, 1, 0, 0, 0, 0); tableSplit = 3'd4; walkOff0 = 1'b1; runReq("R4");
    setReq(2'd2, 32'h0800_0000, 1, 0, 0, 0, 0); tableSplit = 3'd4; walkOff1 = 1'b1; runReq("R4");
    // R5: invalid first-level encodings, and a valid section
    tL1 = 32'h0000_0000; setReq(2'd2, 32'h100, 1, 0, 0, 0, 0); runReq("R5");
    tL1 = 32'hFFFF_FFFF; setReq(2'd2, 32'h100, 1, 1, 1, 1, 0); runReq("R5");
    tL1 = 32'h0000_0402; setReq(2'd2, 32'h100, 1, 1, 1, 1, 0); runReq("R5");
    // R6: coarse table then invalid second level
    tL1 = 32'h0000_0001; tL2 = 32'h0000_0000; setReq(2'd0, 32'h3, 1, 0, 0, 0, 0); runReq("R6");
    // R7: section with flag clear, check active vs inactive
    tL1 = 32'h0000_0002; setReq(2'd2, 32'h40, 1, 1, 0, 1, 0); runReq("R7");
    tL1 = 32'h0000_0002; setReq(2'd2, 32'h40, 1, 0, 1, 1, 0); runReq("R7");
    // R8: page flag clear, and invalid outranks the flag
    tL1 = 32'h0000_0001; tL2 = 32'h0000_0002; setReq(2'd2, 32'h40, 1, 1, 1, 0, 1); runReq("R8");
    tL2 = 32'h0000_0000; setReq(2'd2, 32'h40, 1, 1, 1, 1, 1); runReq("R8");
    // R9: only the copy matching the security state counts
    tL1 = 32'h0000_0002; setReq(2'd2, 32'h40, 1, 1, 1, 0, 0); runReq("R9");
    tL1 = 32'h0000_0002; setReq(2'd2, 32'h40, 1, 1, 0, 1, 1); runReq("R9");
    tL1 = 32'h0000_0002; setReq(2'd2, 32'h40, 1, 1, 1, 0, 1); runReq("R9");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      reqSize = 2'($urandom_range(0, 3));
      reqVa = $urandom;
      if ($urandom_range(0, 3) != 0) reqVa[2:0] = 3'b000;
      mmuOn = ($urandom_range(0, 9) != 0);
      walkOff0 = ($urandom_range(0, 4) == 0);
      walkOff1 = ($urandom_range(0, 4) == 0);
      tableSplit = 3'($urandom_range(0, 7));
      extMode = 1'($urandom);
      forceAccSec = 1'($urandom);
      forceAccNs = 1'($urandom);
      reqSecure = 1'($urandom);
      tL1 = $urandom;
      tL2 = $urandom;
      if ($urandom_range(0, 1) == 1) tL1[1:0] = 2'b01;
      runReq("");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule